// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the device-side control logic of a byte-wide, electrically erasable flash array. It watches an asynchronous memory-style bus made of active-low chip, output and write enables, an address and a data byte. Each write pulse counts as a command cycle. A small command register, made of a mode state machine, decides what later reads return. A read can return an array byte, one of two identifier bytes, or the byte at an address latched by a verify command.

The block also runs the internal program and erase operations. A program operation clears bits only: the stored byte becomes the old byte ANDed with the new data. An erase sweeps the whole array to all-ones. Each operation continues until a verify command ends it. If no verify command arrives, a stop timer halts the operation after a parameterised number of clocks, and the controller then waits for a verify or reset command.

Commands are honoured only while the high-voltage-present flag is high. When the flag is low the controller drops back to plain array reads. The array sits inside the block as an inferred dual-port RAM. A supply-lockout flag keeps the array from being changed.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `hv_ok` is low, the mode is array read, `busy` is low within one clock, any running operation stops, and written command bytes have no effect on what reads return.
- R2: After reset, the controller is in array-read mode, and `busy`, `dout_en` and `dout` are all 0.
- R3: A write cycle needs `ce_n` low. The address is taken when `we_n` falls and the data byte when `we_n` rises. A `we_n` pulse with `ce_n` high is ignored.
- R4: Writing 90h selects identifier mode. In this mode a read at address 0 returns 20h, a read at address 1 returns A8h, and a read at any other address returns 00h.
- R5: Writing 40h arms programming. The next write supplies both address and data, starts the operation (`busy` goes high) and stores the old byte ANDed with the data.
- R6: Writing C0h ends a program operation (`busy` goes low). Reads then return the byte at the programmed address, whatever address is on the bus.
- R7: Erase starts only when 20h is written in two consecutive cycles. It sets every byte to FFh within 2^ADDR_W clocks and stays busy until it is stopped. If 20h is followed by any other code, that code is decoded as a new command.
- R8: Writing A0h ends an erase in progress and latches its own write address. Reads then return the byte at the latched address.
- R9: If no command ends an operation, `busy` falls after PROG_LIMIT clocks for a program or ERASE_LIMIT clocks for an erase. The controller then reads the array and accepts verify or reset commands.
- R10: Two FFh writes in a row return the controller to array read. A single FFh followed by another code is decoded as that code.
- R11: A data byte that is not one of 00h, 20h, 40h, 90h, A0h, C0h or FFh leaves the mode unchanged.
- R12: While `lockout` is high, program and erase operations leave the array unchanged.
- R13: Writing 00h selects array read. In this mode reads return the byte at the bus address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus pins are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data byte written on the bus |
| hv_ok | input | 1 | Programming voltage present; enables the command register |
| lockout | input | 1 | Supply lockout; blocks all array changes |
| dout | output | DATA_W | Registered read data, 0 when no read is active |
| dout_en | output | 1 | High while a read cycle drives `dout` |
| busy | output | 1 | Program or erase operation in progress |

## Verification
The bench targets the sequencing corners:
- a 20h followed by a different code;
- a single FFh followed by a different code;
- an unknown code written in identifier mode.

A decoder that remembered too little or too much history would, in these cases, start an erase, stay stuck in a setup state, or leave identifier mode. It reprograms the same byte twice and splits the address between the two write-enable edges. A design that overwrote instead of ANDing, or that took the address at the wrong edge, would return a wrong verify byte. It lets the stop timer expire on both operations and drops `hv_ok` in the middle of one. It then checks that the array was untouched under `lockout` and that a verify after a timeout still reads the latched byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    M_READ,
    M_IDENT,
    M_ERS_SET,
    M_ERASING,
    M_ERS_VFY,
    M_PRG_SET,
    M_PROGRAMMING,
    M_PRG_VFY,
    M_RST_SET,
    M_HALTED
  } mode_t;

  typedef enum logic [1:0] {
    SRC_ARRAY,
    SRC_ID_LO,
    SRC_ID_HI,
    SRC_ZERO
  } rd_src_t;

  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_ERS_VFY = 8'hA0;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_PRG_VFY = 8'hC0;
  localparam logic [7:0] CMD_RESET   = 8'hFF;

  localparam logic [7:0] ID_MAKER  = 8'h20;
  localparam logic [7:0] ID_DEVICE = 8'hA8;

endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_act,
  output logic [ADDR_W-1:0] rd_addr
);

  logic              ce_s, oe_s, we_s, we_d;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              we_fall, we_rise;

  // first stage: bring the bus pins into the clock domain
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_s   <= 1'b1;
      oe_s   <= 1'b1;
      we_s   <= 1'b1;
      we_d   <= 1'b1;
      addr_s <= '0;
      din_s  <= '0;
    end else begin
      ce_s   <= ce_n;
      oe_s   <= oe_n;
      we_s   <= we_n;
      we_d   <= we_s;
      addr_s <= addr;
      din_s  <= din;
    end
  end

  assign we_fall = we_d & ~we_s & ~ce_s;
  assign we_rise = ~we_d & we_s & ~ce_s;

  // address on the falling edge, data and the command event on the rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_evt  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_evt <= we_rise;
      if (we_fall) wr_addr <= addr_s;
      if (we_rise) wr_data <= din_s;
    end
  end

  assign rd_act  = ~ce_s & ~oe_s & we_s;
  assign rd_addr = addr_s;

  // R3: one command event per write pulse
  assert_evt_single_R3: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> !wr_evt);

endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // port A: operation engine, read-before-write
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  // port B: bus reads
  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int PROG_LIMIT  = 64,
  parameter int ERASE_LIMIT = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hv_ok,
  input  logic              lockout,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] a_rdata,
  output mode_t             mode,
  output logic              busy,
  output logic              a_we,
  output logic [ADDR_W-1:0] a_addr,
  output logic [DATA_W-1:0] a_wdata,
  output logic [ADDR_W-1:0] vfy_addr
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXL  = (ERASE_LIMIT > PROG_LIMIT) ? ERASE_LIMIT : PROG_LIMIT;
  localparam int CW    = $clog2(MAXL + 1);
  localparam logic [CW-1:0]     P_LAST = CW'(PROG_LIMIT - 1);
  localparam logic [CW-1:0]     E_LAST = CW'(ERASE_LIMIT - 1);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(DEPTH - 1);

  mode_t             mode_q, cmd_mode;
  logic              cmd_known;
  logic [ADDR_W-1:0] pa_q, ev_q, sweep_q;
  logic [DATA_W-1:0] pd_q;
  logic [1:0]        ph_q;
  logic              sweep_done_q;
  logic [CW-1:0]     cnt_q;
  logic              op_prog, op_erase;

  assign op_prog  = (mode_q == M_PROGRAMMING);
  assign op_erase = (mode_q == M_ERASING);

  // one-cycle command decode
  always_comb begin
    cmd_known = 1'b1;
    cmd_mode  = mode_q;
    case (wr_data)
      DATA_W'(CMD_READ):    cmd_mode = M_READ;
      DATA_W'(CMD_IDENT):   cmd_mode = M_IDENT;
      DATA_W'(CMD_ERASE):   cmd_mode = M_ERS_SET;
      DATA_W'(CMD_ERS_VFY): cmd_mode = M_ERS_VFY;
      DATA_W'(CMD_PROG):    cmd_mode = M_PRG_SET;
      DATA_W'(CMD_PRG_VFY): cmd_mode = M_PRG_VFY;
      DATA_W'(CMD_RESET):   cmd_mode = M_RST_SET;
      default:              cmd_known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= M_READ;
      pa_q         <= '0;
      pd_q         <= '0;
      ev_q         <= '0;
      ph_q         <= 2'd0;
      sweep_q      <= '0;
      sweep_done_q <= 1'b1;
      cnt_q        <= '0;
    end else if (!hv_ok) begin
      mode_q       <= M_READ;
      ph_q         <= 2'd0;
      sweep_done_q <= 1'b1;
      cnt_q        <= '0;
    end else begin
      // stop timer
      if (op_prog || op_erase) begin
        cnt_q <= cnt_q + 1'b1;
        if ((op_prog && cnt_q == P_LAST) || (op_erase && cnt_q == E_LAST)) begin
          mode_q <= M_HALTED;
          ph_q   <= 2'd0;
          cnt_q  <= '0;
        end
      end
      // program read-modify-write: phase 1 reads, phase 2 writes
      if (op_prog) begin
        if (ph_q == 2'd1)      ph_q <= 2'd2;
        else if (ph_q == 2'd2) ph_q <= 2'd0;
      end
      // erase sweep, one byte per clock
      if (op_erase && !sweep_done_q) begin
        sweep_q <= sweep_q + 1'b1;
        if (sweep_q == A_LAST) sweep_done_q <= 1'b1;
      end
      // bus command cycle overrides the above
      if (wr_evt) begin
        if (mode_q == M_PRG_SET) begin
          pa_q   <= wr_addr;
          pd_q   <= wr_data;
          mode_q <= M_PROGRAMMING;
          ph_q   <= 2'd1;
          cnt_q  <= '0;
        end else if (mode_q == M_ERS_SET && wr_data == DATA_W'(CMD_ERASE)) begin
          mode_q       <= M_ERASING;
          sweep_q      <= '0;
          sweep_done_q <= 1'b0;
          cnt_q        <= '0;
        end else if (mode_q == M_RST_SET && wr_data == DATA_W'(CMD_RESET)) begin
          mode_q <= M_READ;
        end else if (cmd_known) begin
          mode_q       <= cmd_mode;
          ph_q         <= 2'd0;
          sweep_done_q <= 1'b1;
          cnt_q        <= '0;
          if (cmd_mode == M_ERS_VFY) ev_q <= wr_addr;
        end
      end
    end
  end

  assign mode     = mode_q;
  assign busy     = op_prog | op_erase;
  assign a_we     = hv_ok && !lockout &&
                    ((op_prog && ph_q == 2'd2) || (op_erase && !sweep_done_q));
  assign a_addr   = op_erase ? sweep_q : pa_q;
  assign a_wdata  = op_erase ? {DATA_W{1'b1}} : (a_rdata & pd_q);
  assign vfy_addr = (mode_q == M_PRG_VFY) ? pa_q : ev_q;

  // R1: no programming voltage means plain array read
  assert_hv_low_read_R1: assert property (@(posedge clk) disable iff (rst)
    !hv_ok |=> (mode_q == M_READ && !busy));

  // R9: operations never outlive their stop-timer window
  assert_prog_window_R9: assert property (@(posedge clk) disable iff (rst)
    op_prog |-> (cnt_q <= P_LAST));
  assert_erase_window_R9: assert property (@(posedge clk) disable iff (rst)
    op_erase |-> (cnt_q <= E_LAST));

  // R7: erase only follows an erase setup
  assert_erase_entry_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(op_erase) |-> ($past(mode_q) == M_ERS_SET));

  // R5: programming only follows a program setup
  assert_prog_entry_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(op_prog) |-> ($past(mode_q) == M_PRG_SET));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int PROG_LIMIT  = 64,
  parameter int ERASE_LIMIT = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              hv_ok,
  input  logic              lockout,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);

  logic              wr_evt, rd_act;
  logic [ADDR_W-1:0] wr_addr, rd_addr, vfy_addr, arr_a_addr, arr_b_addr;
  logic [DATA_W-1:0] wr_data, arr_a_wdata, arr_a_rdata, arr_b_rdata;
  logic              arr_a_we;
  mode_t             mode;
  rd_src_t           src_sel, src_q;
  logic              rd_q;

  flash_bus_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_act(rd_act), .rd_addr(rd_addr)
  );

  flash_cmd_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PROG_LIMIT(PROG_LIMIT), .ERASE_LIMIT(ERASE_LIMIT)
  ) u_fsm (
    .clk(clk), .rst(rst), .hv_ok(hv_ok), .lockout(lockout),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data),
    .a_rdata(arr_a_rdata), .mode(mode), .busy(busy),
    .a_we(arr_a_we), .a_addr(arr_a_addr), .a_wdata(arr_a_wdata),
    .vfy_addr(vfy_addr)
  );

  flash_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .a_we(arr_a_we), .a_addr(arr_a_addr), .a_wdata(arr_a_wdata),
    .a_rdata(arr_a_rdata), .b_addr(arr_b_addr), .b_rdata(arr_b_rdata)
  );

  // read address and source steering
  assign arr_b_addr = (mode == M_ERS_VFY || mode == M_PRG_VFY) ? vfy_addr : rd_addr;

  always_comb begin
    src_sel = SRC_ARRAY;
    if (mode == M_IDENT) begin
      if (rd_addr == ADDR_W'(0))      src_sel = SRC_ID_LO;
      else if (rd_addr == ADDR_W'(1)) src_sel = SRC_ID_HI;
      else                            src_sel = SRC_ZERO;
    end
  end

  // stage aligned with the array read, then the registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      src_q   <= SRC_ARRAY;
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      rd_q    <= rd_act;
      src_q   <= src_sel;
      dout_en <= rd_q;
      if (!rd_q) dout <= '0;
      else begin
        case (src_q)
          SRC_ID_LO: dout <= DATA_W'(ID_MAKER);
          SRC_ID_HI: dout <= DATA_W'(ID_DEVICE);
          SRC_ZERO:  dout <= '0;
          default:   dout <= arr_b_rdata;
        endcase
      end
    end
  end

  // R4: identifier codes reach the output
  assert_ident_maker_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_q && src_q == SRC_ID_LO) |=> (dout == DATA_W'(ID_MAKER) && dout_en));
  assert_ident_device_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_q && src_q == SRC_ID_HI) |=> (dout == DATA_W'(ID_DEVICE) && dout_en));

endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int PLIM  = 64;
  localparam int ELIM  = 2048;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          hv_ok = 1'b1, lockout = 1'b0;
  logic [DW-1:0] dout;
  logic          dout_en, busy;

  int total = 0;
  int bad = 0;
  logic [7:0] ref_mem [DEPTH];

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_LIMIT(PLIM), .ERASE_LIMIT(ELIM)) i_flash_cmd_ctrl (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .hv_ok(hv_ok), .lockout(lockout),
    .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus write; address may change between the two write-enable edges
  task automatic wr2(input logic [AW-1:0] a_fall, input logic [AW-1:0] a_rise,
                     input logic [7:0] d, input bit ce_low);
    addr = a_fall; ce_n = !ce_low; cyc(2);
    we_n = 1'b0; cyc(3);
    addr = a_rise; din = d; cyc(3);
    we_n = 1'b1; cyc(3);
    ce_n = 1'b1; cyc(2);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr2(a, a, d, 1'b1);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; cyc(6);
    v = dout;
    chk("R13 dout_en during read", dout_en, 1);
    oe_n = 1'b1; ce_n = 1'b1; cyc(4);
  endtask

  function automatic logic [7:0] prog_model(input logic [7:0] old, input logic [7:0] d);
    return old & d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int seed;
    int a, a2;
    logic [7:0] d1, d2;
    seed = $urandom(32'd20240611);

    cyc(5);
    chk("R2 reset dout_en", dout_en, 0);
    chk("R2 reset busy", busy, 0);
    chk("R2 reset dout", dout, 0);
    rst = 1'b0; cyc(3);
    chk("R2 busy after reset", busy, 0);

    // full erase to a known array
    wr(0, 8'h20); wr(0, 8'h20); cyc(2);
    chk("R7 erase busy", busy, 1);
    cyc(DEPTH + 20);
    chk("R7 erase still busy before stop", busy, 1);
    wr(5, 8'hA0);
    chk("R8 A0 ends erase", busy, 0);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    rd(5, v);   chk("R8 erase verify byte", v, 8'hFF);
    rd(9, v);   chk("R8 verify ignores bus address", v, 8'hFF);
    cyc(1);
    chk("R13 dout_en idle", dout_en, 0);

    wr(0, 8'h00);
    for (int i = 0; i < 4; i++) begin
      a = $urandom % DEPTH;
      rd(AW'(a), v); chk("R13 read erased", v, ref_mem[a]);
    end

    // identifier
    wr(0, 8'h90);
    rd(0, v); chk("R4 maker code", v, 8'h20);
    rd(1, v); chk("R4 device code", v, 8'hA8);
    rd(7, v); chk("R4 other address", v, 8'h00);
    wr(0, 8'h55);
    rd(1, v); chk("R11 unknown code keeps mode", v, 8'hA8);

    // reset sequences
    wr(0, 8'hFF); wr(0, 8'h90);
    rd(0, v); chk("R10 single FF then 90", v, 8'h20);
    wr(0, 8'hFF); wr(0, 8'hFF);
    rd(0, v); chk("R10 double FF to read", v, ref_mem[0]);

    // random programming, each byte programmed twice
    for (int i = 0; i < 12; i++) begin
      a  = $urandom % DEPTH;
      d1 = 8'($urandom);
      d2 = 8'($urandom);
      wr(0, 8'h40); wr(AW'(a), d1);
      chk("R5 program busy", busy, 1);
      wr(0, 8'hC0);
      chk("R6 C0 ends program", busy, 0);
      ref_mem[a] = prog_model(ref_mem[a], d1);
      rd(AW'(a ^ 3), v); chk("R6 verify latched byte", v, ref_mem[a]);
      wr(0, 8'h40); wr(AW'(a), d2); wr(0, 8'hC0);
      ref_mem[a] = prog_model(ref_mem[a], d2);
      rd(AW'(a), v); chk("R5 AND of two programs", v, ref_mem[a]);
      wr(0, 8'h00);
      rd(AW'(a), v); chk("R13 read programmed", v, ref_mem[a]);
    end

    // address taken at falling edge
    wr(0, 8'h40); wr2(10, 20, 8'h3C, 1'b1); wr(0, 8'hC0);
    ref_mem[10] = prog_model(ref_mem[10], 8'h3C);
    rd(0, v); chk("R3 address at WE fall", v, ref_mem[10]);
    wr(0, 8'h00);
    rd(20, v); chk("R3 rise address untouched", v, ref_mem[20]);

    // erase setup followed by other code
    wr(0, 8'h20); wr(0, 8'h90); cyc(2);
    chk("R7 20 then 90 no erase", busy, 0);
    rd(1, v); chk("R7 20 then 90 gives identifier", v, 8'hA8);

    // program stop timer
    wr(0, 8'hFF); wr(0, 8'hFF);
    a2 = 300;
    wr(0, 8'h40); wr(AW'(a2), 8'h0F);
    chk("R9 program busy", busy, 1);
    cyc(PLIM + 10);
    chk("R9 program stop timer", busy, 0);
    ref_mem[a2] = prog_model(ref_mem[a2], 8'h0F);
    rd(AW'(a2), v); chk("R9 halted reads array", v, ref_mem[a2]);
    wr(0, 8'hC0);
    rd(0, v); chk("R9 verify after halt", v, ref_mem[a2]);

    // erase stop timer
    wr(0, 8'h20); wr(0, 8'h20);
    cyc(ELIM + 20);
    chk("R9 erase stop timer", busy, 0);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    rd(AW'(a2), v); chk("R7 full erase", v, 8'hFF);

    // lockout
    wr(0, 8'h40); wr(4, 8'h00); wr(0, 8'hC0);
    ref_mem[4] = 8'h00;
    lockout = 1'b1;
    wr(0, 8'h40); wr(3, 8'h00); wr(0, 8'hC0);
    rd(0, v); chk("R12 program under lockout", v, 8'hFF);
    wr(0, 8'h20); wr(0, 8'h20); cyc(DEPTH + 20); wr(4, 8'hA0);
    rd(4, v); chk("R12 erase under lockout", v, 8'h00);
    lockout = 1'b0;
    wr(0, 8'h00);

    // programming voltage
    hv_ok = 1'b0; cyc(2);
    wr(0, 8'h90);
    rd(0, v); chk("R1 command ignored without hv", v, ref_mem[0]);
    hv_ok = 1'b1; cyc(2);
    wr(0, 8'h90);
    rd(0, v); chk("R4 identifier with hv", v, 8'h20);
    hv_ok = 1'b0; cyc(3);
    rd(0, v); chk("R1 hv drop returns to read", v, ref_mem[0]);
    hv_ok = 1'b1; cyc(2);
    wr(0, 8'h40); wr(6, 8'h00);
    chk("R5 busy before drop", busy, 1);
    hv_ok = 1'b0; cyc(2);
    chk("R1 hv drop stops program", busy, 0);
    hv_ok = 1'b1; cyc(2);

    // write pulse with chip enable high
    wr2(0, 0, 8'h90, 1'b0);
    rd(0, v); chk("R3 CE high write ignored", v, ref_mem[0]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule